// File: doc/BRIEF.md
# Chopper Current Limiter with Short Discrimination

This block paces the chopper that keeps an H-bridge output current under its limit. It also tells ordinary over-limit operation apart from hard short circuits. All of its inputs are comparator flags that have already been synchronized to the clock:

- `lim_hit`: the load current is above the limit.
- `ls_sc`: the low-side current of an output is above the short-circuit threshold.
- `hs_sc`: the high-side current of an output is above the short-circuit threshold.

When the current stays over the limit for a whole blanking window, the bridge is switched off for a fixed off time and then released. A low-side short-threshold crossing seen inside that window is not treated as current limiting. It is classed as a short to supply on that output. A high-side short indication that survives a filter time is classed as a short to ground. When messages from both sides arrive within a pairing window of each other, a single short across the load is reported instead.

The outputs are a bridge-off request, a one-cycle pulse at the start of each chop, and one-cycle short event pulses. A downstream fault latch consumes these pulses. The bridge-off request also covers the pairing window, so the bridge is already off while the kind of short is being decided. All times are parameters given in clock cycles. `BLANK_CYC` and `FILT_CYC` must be at least 2, and `WIN_CYC` at least 1.

Top module: `chopper_guard`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `bridge_off`, `climit_evt`, `scb_evt`, `scg_evt` and `scol_evt` are all 0.
- R2: When `lim_hit` is sampled high on BLANK_CYC consecutive clock edges outside the off time, `bridge_off` rises and `climit_evt` pulses after the last of those edges.
- R3: The chopper off time lasts exactly OFF_CYC cycles, during which `lim_hit` has no effect. If `lim_hit` is still high afterwards, a new full blanking window begins.
- R4: If `lim_hit` is sampled low before the blanking window completes, the blanking count restarts from zero.
- R5: A crossing of `ls_sc[i]` sampled together with `lim_hit` outside the off time raises `bridge_off` on that edge. If no high-side message pairs with it, `scb_evt` pulses with bit i set WIN_CYC cycles later, and `bridge_off` falls on that same cycle.
- R6: `ls_sc` is ignored while the chopper off time runs.
- R7: `hs_sc[i]` held high for FILT_CYC consecutive samples raises `bridge_off` on the last of those edges. If nothing pairs with it, `scg_evt` pulses with bit i set WIN_CYC cycles later. A high pulse shorter than FILT_CYC samples produces nothing.
- R8: If a message from the other side arrives on the same edge as the first message, or within WIN_CYC cycles after it (inclusive), `scol_evt` pulses on that edge instead of `scb_evt` or `scg_evt`, and the pending window ends. A message one cycle later starts a new window.
- R9: A short input that is held high yields one message per crossing. No repeat happens until that input returns low.
- R10: Every event output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_hit | input | 1 | Current above the chopper limit |
| ls_sc | input | N_OUT | Per-output low-side current above the short threshold |
| hs_sc | input | N_OUT | Per-output high-side current above the short threshold |
| bridge_off | output | 1 | Request to switch every output stage off |
| climit_evt | output | 1 | Pulse when a chop (off time) starts |
| scb_evt | output | N_OUT | Pulse: short to supply, one bit per output |
| scg_evt | output | N_OUT | Pulse: short to ground, one bit per output |
| scol_evt | output | 1 | Pulse: short across the load |

## Verification
The bench builds the block with a blanking window of 4 cycles, an off time of 6, and a filter and pairing window of 3. These short values place every timing edge within a few dozen cycles. The stimulus covers two full chop periods with the limit held high, a blanking run aborted one sample early, and high-side glitches one sample too short. Pairing is tested at the last cycle of the window, one cycle past it, and on the same edge. Each expected pulse and each edge of the bridge-off request is queued with its exact cycle, so any shift in the counts shows up as a mismatch or as an unexpected event.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_BLANK = 2'd1,
    CH_OFF   = 2'd2
  } chop_st_e;
endpackage

// File: rtl/chop_timer.sv
module chop_timer
  import chop_pkg::*;
#(
  parameter int N_OUT     = 2,
  parameter int BLANK_CYC = 650,
  parameter int OFF_CYC   = 800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lim_hit,
  input  logic [N_OUT-1:0] ls_sc,
  output logic             off_q,
  output logic             clim_q,
  output logic [N_OUT-1:0] ls_msg
);
  localparam int MAXC = (BLANK_CYC > OFF_CYC) ? BLANK_CYC : OFF_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] TB_LAST = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] TA_LAST = CW'(OFF_CYC);

  chop_st_e        st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            clim_n;
  logic [N_OUT-1:0] seen_q;
  logic            win_open;

  assign win_open = lim_hit && (st_q != CH_OFF);

  // A low-side crossing counts once while the window is open
  always_comb begin
    for (int i = 0; i < N_OUT; i++)
      ls_msg[i] = win_open && ls_sc[i] && !seen_q[i];
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    clim_n = 1'b0;
    unique case (st_q)
      CH_IDLE: begin
        if (lim_hit && (ls_msg == '0)) begin
          st_n  = CH_BLANK;
          cnt_n = CW'(1);
        end
      end
      CH_BLANK: begin
        if ((ls_msg != '0) || !lim_hit) begin
          st_n  = CH_IDLE;
          cnt_n = '0;
        end else if (cnt_q == TB_LAST) begin
          st_n   = CH_OFF;
          cnt_n  = CW'(1);
          clim_n = 1'b1;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      CH_OFF: begin
        if (cnt_q == TA_LAST) begin
          st_n  = CH_IDLE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      default: begin
        st_n  = CH_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CH_IDLE;
      cnt_q  <= '0;
      off_q  <= 1'b0;
      clim_q <= 1'b0;
      seen_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      off_q  <= (st_n == CH_OFF);
      clim_q <= clim_n;
      seen_q <= ls_sc & (seen_q | ls_msg);
    end
  end
endmodule

// File: rtl/hs_filter.sv
module hs_filter #(
  parameter int N_OUT    = 2,
  parameter int FILT_CYC = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] hs_sc,
  output logic [N_OUT-1:0] hs_msg
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] F_LAST = FW'(FILT_CYC - 1);
  localparam logic [FW-1:0] F_SAT  = FW'(FILT_CYC);

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic [FW-1:0] run_q;
    always_ff @(posedge clk) begin
      if (rst || !hs_sc[g]) run_q <= '0;
      else if (run_q != F_SAT) run_q <= run_q + FW'(1);
    end
    assign hs_msg[g] = hs_sc[g] && (run_q == F_LAST);
  end
endmodule

// File: rtl/short_arbiter.sv
module short_arbiter #(
  parameter int N_OUT   = 2,
  parameter int WIN_CYC = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] hs_msg,
  input  logic [N_OUT-1:0] ls_msg,
  output logic             pend_q,
  output logic [N_OUT-1:0] scb_q,
  output logic [N_OUT-1:0] scg_q,
  output logic             scol_q
);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam logic [WW-1:0] W_END = WW'(WIN_CYC);

  logic [N_OUT-1:0] phs_q, pls_q, phs_n, pls_n, hs_all, ls_all, scb_n, scg_n;
  logic [WW-1:0]    wcnt_q, wcnt_n;
  logic             scol_n, busy;

  assign hs_all = phs_q | hs_msg;
  assign ls_all = pls_q | ls_msg;
  assign busy   = (phs_q != '0) || (pls_q != '0);

  always_comb begin
    phs_n  = phs_q;
    pls_n  = pls_q;
    wcnt_n = wcnt_q;
    scb_n  = '0;
    scg_n  = '0;
    scol_n = 1'b0;
    if ((hs_all != '0) && (ls_all != '0)) begin
      scol_n = 1'b1;
      phs_n  = '0;
      pls_n  = '0;
      wcnt_n = '0;
    end else if (busy) begin
      if (wcnt_q == W_END) begin
        scb_n  = ls_all;
        scg_n  = hs_all;
        phs_n  = '0;
        pls_n  = '0;
        wcnt_n = '0;
      end else begin
        phs_n  = hs_all;
        pls_n  = ls_all;
        wcnt_n = wcnt_q + WW'(1);
      end
    end else if ((hs_msg != '0) || (ls_msg != '0)) begin
      phs_n  = hs_msg;
      pls_n  = ls_msg;
      wcnt_n = WW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phs_q  <= '0;
      pls_q  <= '0;
      wcnt_q <= '0;
      pend_q <= 1'b0;
      scb_q  <= '0;
      scg_q  <= '0;
      scol_q <= 1'b0;
    end else begin
      phs_q  <= phs_n;
      pls_q  <= pls_n;
      wcnt_q <= wcnt_n;
      pend_q <= (phs_n != '0) || (pls_n != '0);
      scb_q  <= scb_n;
      scg_q  <= scg_n;
      scol_q <= scol_n;
    end
  end
endmodule

// File: rtl/chopper_guard.sv
module chopper_guard #(
  parameter int N_OUT     = 2,
  parameter int BLANK_CYC = 650,
  parameter int OFF_CYC   = 800,
  parameter int FILT_CYC  = 100,
  parameter int WIN_CYC   = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lim_hit,
  input  logic [N_OUT-1:0] ls_sc,
  input  logic [N_OUT-1:0] hs_sc,
  output logic             bridge_off,
  output logic             climit_evt,
  output logic [N_OUT-1:0] scb_evt,
  output logic [N_OUT-1:0] scg_evt,
  output logic             scol_evt
);
  logic             chop_off, pend;
  logic [N_OUT-1:0] ls_msg, hs_msg;

  chop_timer #(.N_OUT(N_OUT), .BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC)) u_timer (
    .clk(clk), .rst(rst), .lim_hit(lim_hit), .ls_sc(ls_sc),
    .off_q(chop_off), .clim_q(climit_evt), .ls_msg(ls_msg)
  );

  hs_filter #(.N_OUT(N_OUT), .FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst(rst), .hs_sc(hs_sc), .hs_msg(hs_msg)
  );

  short_arbiter #(.N_OUT(N_OUT), .WIN_CYC(WIN_CYC)) u_arb (
    .clk(clk), .rst(rst), .hs_msg(hs_msg), .ls_msg(ls_msg),
    .pend_q(pend), .scb_q(scb_evt), .scg_q(scg_evt), .scol_q(scol_evt)
  );

  assign bridge_off = chop_off | pend;
endmodule

// File: rtl/chopper_guard_chk.sv
module chopper_guard_chk #(
  parameter int N_OUT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bridge_off,
  input logic             climit_evt,
  input logic [N_OUT-1:0] scb_evt,
  input logic [N_OUT-1:0] scg_evt,
  input logic             scol_evt
);
  // R2
  clim_off_chk: assert property (@(posedge clk) disable iff (rst)
    climit_evt |-> bridge_off);
  // R3
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    climit_evt |=> bridge_off);
  // R10
  clim_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    climit_evt |=> !climit_evt);
  // R10
  scol_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scol_evt |=> !scol_evt);
  // R10
  scb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (scb_evt != '0) |=> (scb_evt == '0));
  // R10
  scg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (scg_evt != '0) |=> (scg_evt == '0));
  // R8
  scol_excl_chk: assert property (@(posedge clk) disable iff (rst)
    scol_evt |-> ((scb_evt == '0) && (scg_evt == '0)));
  // R5
  scb_held_chk: assert property (@(posedge clk) disable iff (rst)
    (scb_evt != '0) |-> $past(bridge_off));
  // R7
  scg_held_chk: assert property (@(posedge clk) disable iff (rst)
    (scg_evt != '0) |-> $past(bridge_off));
endmodule

bind chopper_guard chopper_guard_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .bridge_off(bridge_off), .climit_evt(climit_evt),
  .scb_evt(scb_evt), .scg_evt(scg_evt), .scol_evt(scol_evt)
);

// File: tb/sim_chopper_guard.sv
module sim_chopper_guard;
  localparam int TB = 4, TA = 6, TF = 3, TW = 3;
  localparam int K_RISE = 0, K_FALL = 1, K_CLIM = 2, K_SCB = 3, K_SCG = 4, K_SCOL = 5;

  typedef struct {
    int         kind;
    logic [1:0] vec;
    int         cyc;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lim_hit = 1'b0;
  logic [1:0] ls_sc = '0, hs_sc = '0;
  logic       bridge_off, climit_evt, scol_evt;
  logic [1:0] scb_evt, scg_evt;

  int    cyc = 0, checks = 0, fails = 0;
  logic  prev_off = 1'b0;
  item_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chopper_guard #(.N_OUT(2), .BLANK_CYC(TB), .OFF_CYC(TA), .FILT_CYC(TF), .WIN_CYC(TW)) u0 (
    .clk(clk), .rst(rst), .lim_hit(lim_hit), .ls_sc(ls_sc), .hs_sc(hs_sc),
    .bridge_off(bridge_off), .climit_evt(climit_evt), .scb_evt(scb_evt),
    .scg_evt(scg_evt), .scol_evt(scol_evt)
  );

  task automatic expect_ev(int kind, logic [1:0] vec, int at, string req);
    item_t it;
    it.kind = kind; it.vec = vec; it.cyc = at; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic got(int kind, logic [1:0] vec);
    item_t it;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event: actual kind=%0d vec=%b cyc=%0d, expected none", kind, vec, cyc);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != kind || it.vec != vec || it.cyc != cyc) begin
        fails++;
        $display("FAIL %s: actual kind=%0d vec=%b cyc=%0d, expected kind=%0d vec=%b cyc=%0d",
                 it.req, kind, vec, cyc, it.kind, it.vec, it.cyc);
      end
    end
  endtask

  // monitor: scoreboard consumer
  always @(negedge clk) begin
    if (!rst) begin
      if (bridge_off !== prev_off) begin
        got(bridge_off ? K_RISE : K_FALL, 2'b00);
        prev_off = bridge_off;
      end
      if (climit_evt) got(K_CLIM, 2'b00);
      if (scb_evt != 2'b00) got(K_SCB, scb_evt);
      if (scg_evt != 2'b00) got(K_SCG, scg_evt);
      if (scol_evt) got(K_SCOL, 2'b00);
    end
  end

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running, expected finished");
    finish_run();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if ({bridge_off, climit_evt, scb_evt, scg_evt, scol_evt} != '0) begin
      fails++;
      $display("FAIL R1: actual outputs=%b, expected 0",
               {bridge_off, climit_evt, scb_evt, scg_evt, scol_evt});
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({bridge_off, climit_evt, scb_evt, scg_evt, scol_evt} != '0) begin
      fails++;
      $display("FAIL R1 after release: actual outputs=%b, expected 0",
               {bridge_off, climit_evt, scb_evt, scg_evt, scol_evt});
    end

    // S1: R2, R3 two chop periods; R6 low-side ignored while off
    c = cyc;
    expect_ev(K_RISE, 2'b00, c + TB, "R2");
    expect_ev(K_CLIM, 2'b00, c + TB, "R2");
    expect_ev(K_FALL, 2'b00, c + TB + TA, "R3");
    expect_ev(K_RISE, 2'b00, c + 2*TB + TA, "R3");
    expect_ev(K_CLIM, 2'b00, c + 2*TB + TA, "R3");
    expect_ev(K_FALL, 2'b00, c + 2*TB + 2*TA, "R3");
    lim_hit = 1'b1;
    wait_to(c + TB + 1); ls_sc = 2'b11;   // R6
    wait_to(c + TB + 4); ls_sc = 2'b00;
    wait_to(c + 2*TB + TA); lim_hit = 1'b0;
    wait_to(c + 2*TB + 2*TA + 4);

    // S2: R4 abort one sample short, then full window
    c = cyc;
    lim_hit = 1'b1;
    wait_to(c + TB - 1); lim_hit = 1'b0;
    wait_to(c + TB + 1);
    expect_ev(K_RISE, 2'b00, c + 2*TB + 1, "R4");
    expect_ev(K_CLIM, 2'b00, c + 2*TB + 1, "R4");
    expect_ev(K_FALL, 2'b00, c + 2*TB + 1 + TA, "R4");
    lim_hit = 1'b1;
    wait_to(c + 2*TB + 1); lim_hit = 1'b0;
    wait_to(c + 2*TB + TA + 5);

    // S3: R5 short to supply in blanking, R9 held input no repeat
    c = cyc;
    expect_ev(K_RISE, 2'b00, c + 3, "R5");
    expect_ev(K_FALL, 2'b00, c + 3 + TW, "R5");
    expect_ev(K_SCB, 2'b01, c + 3 + TW, "R5");
    lim_hit = 1'b1;
    wait_to(c + 2); ls_sc = 2'b01;
    wait_to(c + 5); ls_sc = 2'b00; lim_hit = 1'b0;
    wait_to(c + 12);

    // S4: R7 glitch ignored, filtered short to ground; R9 held high
    c = cyc;
    hs_sc = 2'b10;
    wait_to(c + TF - 1); hs_sc = 2'b00;
    wait_to(c + 4);
    expect_ev(K_RISE, 2'b00, c + 4 + TF, "R7");
    expect_ev(K_FALL, 2'b00, c + 4 + TF + TW, "R7");
    expect_ev(K_SCG, 2'b10, c + 4 + TF + TW, "R7");
    hs_sc = 2'b10;
    wait_to(c + 12); hs_sc = 2'b00;
    wait_to(c + 18);

    // S5: R8 pairing on the last cycle of the window
    c = cyc;
    expect_ev(K_RISE, 2'b00, c + TF, "R8");
    expect_ev(K_FALL, 2'b00, c + TF + TW, "R8");
    expect_ev(K_SCOL, 2'b00, c + TF + TW, "R8");
    hs_sc = 2'b01;
    wait_to(c + TF + TW - 1); lim_hit = 1'b1; ls_sc = 2'b10;
    wait_to(c + TF + TW); lim_hit = 1'b0; ls_sc = 2'b00; hs_sc = 2'b00;
    wait_to(c + 14);

    // S6: R8 one cycle past the window: separate events
    c = cyc;
    expect_ev(K_RISE, 2'b00, c + TF, "R8");
    expect_ev(K_FALL, 2'b00, c + TF + TW, "R8");
    expect_ev(K_SCG, 2'b10, c + TF + TW, "R8");
    expect_ev(K_RISE, 2'b00, c + TF + TW + 1, "R8");
    expect_ev(K_FALL, 2'b00, c + TF + 2*TW + 1, "R8");
    expect_ev(K_SCB, 2'b01, c + TF + 2*TW + 1, "R8");
    hs_sc = 2'b10;
    wait_to(c + TF + TW); lim_hit = 1'b1; ls_sc = 2'b01;
    wait_to(c + TF + TW + 1); lim_hit = 1'b0; ls_sc = 2'b00; hs_sc = 2'b00;
    wait_to(c + 18);

    // S7: R8 both sides on the same edge
    c = cyc;
    expect_ev(K_SCOL, 2'b00, c + TF, "R8");
    hs_sc = 2'b01;
    wait_to(c + TF - 1); lim_hit = 1'b1; ls_sc = 2'b01;
    wait_to(c + TF); lim_hit = 1'b0; ls_sc = 2'b00; hs_sc = 2'b00;
    wait_to(c + 12);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing events: actual pending=%0d, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule